// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Engine

This block is the host-side mover for two storage channels. Software fills a table in memory with 8-byte transfer descriptors. It writes the table address into a channel's pointer register and then sets that channel's start bit. The engine reads the descriptors one after another through a byte-wide memory port. For each descriptor it moves the stated number of bytes between the descriptor's buffer and the channel's device byte stream. The stream is a valid/ready pair going to the device, or coming from it.

A run ends in one of three ways. The first is completion of the descriptor whose flag byte has bit 7 set. The second is a device interrupt. The third is software clearing the start bit. The status register then shows the outcome: an interrupt flag and an error flag, both cleared by writing 1. Both channels share one memory port, and a round-robin arbiter decides between them. Each channel has its own 8-byte register window: channel 0 at offset 0, channel 1 at offset 8.

Top module: `bmdma_top`

## Requirements
- R1: Within a channel window, offset 0 is the command register (bit 0 start, bit 3 direction, other bits read 0), offset 2 is status (bit 0 active, bit 1 error, bit 2 interrupt), and offset 4 is the 32-bit table pointer. The pointer's low two bits read back as 0 whatever is written. Channel 1's window is channel 0's plus 8, and the two are independent. After reset all registers read 0.
- R2: Writing the start bit as 1 while it is 0 begins a run at the pointer address. Descriptors are fetched in sequence at increasing 8-byte steps.
- R3: A descriptor holds these fields, little-endian: bytes 0-3 buffer address, bytes 4-5 byte count, byte 6 ignored, byte 7 flags. Only flag bit 7 marks the last descriptor; other flag bits have no effect.
- R4: A byte count of zero means 2^LEN_W bytes (65536 at the default LEN_W=16). The count field's low LEN_W bits are used.
- R5: With direction 0, buffer bytes are read in ascending address order and sent to the device in that order. With direction 1, device bytes are written to ascending buffer addresses, and no byte beyond the count is written.
- R6: Status bit 0 is 1 from the start until the last descriptor's final byte is moved, the run halts, or the start bit is written 0. Writing the start bit 0 stops the run.
- R7: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: A device interrupt sets status bit 2. During a run, the engine halts at its next point of waiting on the device, without raising the error flag.
- R9: After the last descriptor completes, if the device still offers or requests a byte before its interrupt arrives, status bit 1 is set.
- R10: Both channels can run at once. At most one memory request is granted per cycle, the grant alternates between requesting channels, and each channel's data stays correct.
- R11: Writing the command register during a run with start still 1 neither restarts the run nor changes its direction. The new direction bit reads back and applies to the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | CH_W+3 | Register byte address (channel in upper bits) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| mem_req_o | output | 1 | Memory request, always accepted |
| mem_we_o | output | 1 | Memory write when 1, read when 0 |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after a read request |
| tx_valid_o | output | NUM_CH | Byte to device valid, per channel |
| tx_data_o | output | 8*NUM_CH | Byte to device, per channel |
| tx_ready_i | input | NUM_CH | Device accepts byte, per channel |
| rx_valid_i | input | NUM_CH | Byte from device valid, per channel |
| rx_data_i | input | 8*NUM_CH | Byte from device, per channel |
| rx_ready_o | output | NUM_CH | Engine accepts byte, per channel |
| irq_i | input | NUM_CH | Device completion pulse, per channel |

## Verification
On every cycle, assertions check the following. The arbiter grants one requester at most, and only one that asks. A halted or interrupted engine goes idle. The error and interrupt flags stay set until a 1 is written to them. The remaining count is never zero while data moves. A byte offered to the device holds steady until it is taken. The bench's scenarios alone can show the rest: byte order against the descriptor layout, the zero-count length, the last-flag decode, the exhaustion error, both channels sharing memory, and a mid-run direction write being ignored. These need a memory model and device stand-ins whose expected contents are computed from the requirements.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_RREQ, S_RWAIT, S_TX, S_RX, S_WREQ, S_TAIL
  } st_e;

  localparam logic [2:0] OFF_CMD = 3'd0;
  localparam logic [2:0] OFF_STS = 3'd2;
  localparam logic [2:0] OFF_PTR = 3'd4;

  localparam int BIT_START = 0;
  localparam int BIT_DIR   = 3;
  localparam int BIT_ERR   = 1;
  localparam int BIT_INT   = 2;
  localparam int LAST_BIT  = 7;
  localparam int DESC_LAST_IDX = 7;
endpackage

// File: rtl/bmdma_arb.sv
module bmdma_arb #(
  parameter int N    = 2,
  parameter int CH_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    gnt_o,
  output logic [CH_W-1:0] gidx_o
);
  logic [CH_W-1:0] last_q;

  always_comb begin
    logic found;
    gnt_o  = '0;
    gidx_o = '0;
    found  = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        gidx_o     = CH_W'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= CH_W'(N - 1);
    else if (|gnt_o)  last_q <= gidx_o;
  end

  p_one_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_grant_has_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [2:0]  off_i,
  input  logic [31:0] wdata_i,
  output logic [7:0]  cmd_o,
  output logic [7:0]  sts_o,
  output logic [31:0] ptr_o,
  output logic        req_o,
  output logic        we_o,
  output logic [31:0] addr_o,
  output logic [7:0]  wdata_o,
  input  logic        gnt_i,
  input  logic [7:0]  rdata_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  input  logic        irq_i
);
  localparam logic [LEN_W:0] REM_FULL = {1'b1, {LEN_W{1'b0}}};
  localparam logic [LEN_W:0] REM_ONE  = (LEN_W + 1)'(1);

  st_e             st_q;
  logic            start_q, dir_q, run_dir_q, err_q, int_q, last_q, run_irq_q;
  logic [29:0]     ptr_q;
  logic [31:0]     tbl_q, buf_q;
  logic [2:0]      fidx_q;
  logic [47:0]     desc_q;
  logic [LEN_W:0]  rem_q;
  logic [7:0]      data_q;

  logic cmd_wr, sts_wr, ptr_wr, go, halt, dev_wait, irq_stop, demand, err_set, active;
  logic [LEN_W-1:0] cnt_raw;
  st_e  data_st;

  assign cmd_wr   = wr_i && off_i == OFF_CMD;
  assign sts_wr   = wr_i && off_i == OFF_STS;
  assign ptr_wr   = wr_i && off_i == OFF_PTR;
  assign go       = cmd_wr && wdata_i[BIT_START] && !start_q;
  assign halt     = cmd_wr && !wdata_i[BIT_START];
  assign dev_wait = st_q == S_TX || st_q == S_RX || st_q == S_TAIL;
  assign irq_stop = dev_wait && (irq_i || run_irq_q);
  assign demand   = run_dir_q ? rx_valid_i : tx_ready_i;
  assign err_set  = st_q == S_TAIL && !irq_stop && demand;
  assign active   = st_q != S_IDLE && st_q != S_TAIL;
  assign cnt_raw  = desc_q[32 +: LEN_W];
  assign data_st  = run_dir_q ? S_RX : S_RREQ;

  assign req_o      = st_q == S_FREQ || st_q == S_RREQ || st_q == S_WREQ;
  assign we_o       = st_q == S_WREQ;
  assign addr_o     = (st_q == S_FREQ) ? tbl_q + {29'd0, fidx_q} : buf_q;
  assign wdata_o    = data_q;
  assign tx_valid_o = st_q == S_TX;
  assign tx_data_o  = data_q;
  assign rx_ready_o = st_q == S_RX;

  assign cmd_o = {4'd0, dir_q, 2'd0, start_q};
  assign sts_o = {5'd0, int_q, err_q, active};
  assign ptr_o = {ptr_q, 2'b00};

  // registers visible to software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      ptr_q   <= '0;
      err_q   <= 1'b0;
      int_q   <= 1'b0;
    end else begin
      if (cmd_wr) begin
        start_q <= wdata_i[BIT_START];
        dir_q   <= wdata_i[BIT_DIR];
      end
      if (ptr_wr) ptr_q <= wdata_i[31:2];
      err_q <= err_set | (err_q & ~(sts_wr & wdata_i[BIT_ERR]));
      int_q <= irq_i   | (int_q & ~(sts_wr & wdata_i[BIT_INT]));
    end
  end

  // transfer engine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      run_dir_q <= 1'b0;
      run_irq_q <= 1'b0;
      tbl_q     <= '0;
      fidx_q    <= '0;
      desc_q    <= '0;
      buf_q     <= '0;
      rem_q     <= '0;
      last_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      if (irq_i && active) run_irq_q <= 1'b1;
      if (halt) begin
        st_q <= S_IDLE;
      end else if (go) begin
        st_q      <= S_FREQ;
        tbl_q     <= {ptr_q, 2'b00};
        fidx_q    <= '0;
        run_dir_q <= wdata_i[BIT_DIR];
        run_irq_q <= 1'b0;
      end else begin
        unique case (st_q)
          S_FREQ:  if (gnt_i) st_q <= S_FWAIT;
          S_FWAIT: begin
            if (fidx_q != 3'(DESC_LAST_IDX)) begin
              if (fidx_q < 3'd6) desc_q[{fidx_q, 3'b000} +: 8] <= rdata_i;
              fidx_q <= fidx_q + 3'd1;
              st_q   <= S_FREQ;
            end else begin
              buf_q  <= desc_q[31:0];
              rem_q  <= (cnt_raw == '0) ? REM_FULL : {1'b0, cnt_raw};
              last_q <= rdata_i[LAST_BIT];
              st_q   <= data_st;
            end
          end
          S_RREQ:  if (gnt_i) st_q <= S_RWAIT;
          S_RWAIT: begin
            data_q <= rdata_i;
            st_q   <= S_TX;
          end
          S_RX: begin
            if (irq_stop) st_q <= S_IDLE;
            else if (rx_valid_i) begin
              data_q <= rx_data_i;
              st_q   <= S_WREQ;
            end
          end
          S_TX, S_WREQ: begin
            if (st_q == S_TX && irq_stop) begin
              st_q <= S_IDLE;
            end else if ((st_q == S_TX && tx_ready_i) || (st_q == S_WREQ && gnt_i)) begin
              buf_q <= buf_q + 32'd1;
              rem_q <= rem_q - REM_ONE;
              if (rem_q == REM_ONE) begin
                if (last_q) st_q <= S_TAIL;
                else begin
                  tbl_q  <= tbl_q + 32'd8;
                  fidx_q <= '0;
                  st_q   <= S_FREQ;
                end
              end else begin
                st_q <= data_st;
              end
            end
          end
          S_TAIL:  if (irq_stop || demand) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  p_halt_idles_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> st_q == S_IDLE);
  p_irq_halts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && dev_wait && !go) |=> (st_q == S_IDLE && int_q));
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(sts_wr && wdata_i[BIT_ERR])) |=> err_q);
  p_int_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_q && !(sts_wr && wdata_i[BIT_INT])) |=> int_q);
  p_rem_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RREQ || st_q == S_RWAIT || st_q == S_TX || st_q == S_RX || st_q == S_WREQ)
      |-> rem_q != '0);
  p_tx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !irq_stop && !halt) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/bmdma_top.sv
module bmdma_top
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int LEN_W  = 16,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [CH_W+2:0]       reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [31:0]           mem_addr_o,
  output logic [7:0]            mem_wdata_o,
  input  logic [7:0]            mem_rdata_i,
  output logic [NUM_CH-1:0]     tx_valid_o,
  output logic [8*NUM_CH-1:0]   tx_data_o,
  input  logic [NUM_CH-1:0]     tx_ready_i,
  input  logic [NUM_CH-1:0]     rx_valid_i,
  input  logic [8*NUM_CH-1:0]   rx_data_i,
  output logic [NUM_CH-1:0]     rx_ready_o,
  input  logic [NUM_CH-1:0]     irq_i
);
  logic [CH_W-1:0] sel;
  logic [2:0]      off;
  logic [NUM_CH-1:0] req, gnt, we;
  logic [CH_W-1:0]   gidx;
  logic [7:0]  cmd_rd [NUM_CH];
  logic [7:0]  sts_rd [NUM_CH];
  logic [31:0] ptr_rd [NUM_CH];
  logic [31:0] addr   [NUM_CH];
  logic [7:0]  wdat   [NUM_CH];

  assign sel = reg_addr_i[CH_W+2:3];
  assign off = reg_addr_i[2:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    bmdma_chan #(.LEN_W(LEN_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_we_i && sel == CH_W'(i)),
      .off_i      (off),
      .wdata_i    (reg_wdata_i),
      .cmd_o      (cmd_rd[i]),
      .sts_o      (sts_rd[i]),
      .ptr_o      (ptr_rd[i]),
      .req_o      (req[i]),
      .we_o       (we[i]),
      .addr_o     (addr[i]),
      .wdata_o    (wdat[i]),
      .gnt_i      (gnt[i]),
      .rdata_i    (mem_rdata_i),
      .tx_valid_o (tx_valid_o[i]),
      .tx_data_o  (tx_data_o[8*i +: 8]),
      .tx_ready_i (tx_ready_i[i]),
      .rx_valid_i (rx_valid_i[i]),
      .rx_data_i  (rx_data_i[8*i +: 8]),
      .rx_ready_o (rx_ready_o[i]),
      .irq_i      (irq_i[i])
    );
  end

  bmdma_arb #(.N(NUM_CH), .CH_W(CH_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .gnt_o  (gnt),
    .gidx_o (gidx)
  );

  assign mem_req_o   = |gnt;
  assign mem_we_o    = |(gnt & we);
  assign mem_addr_o  = addr[gidx];
  assign mem_wdata_o = wdat[gidx];

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel == CH_W'(i)) begin
        unique case (off)
          OFF_CMD: reg_rdata_o = {24'd0, cmd_rd[i]};
          OFF_STS: reg_rdata_o = {24'd0, sts_rd[i]};
          OFF_PTR: reg_rdata_o = ptr_rd[i];
          default: reg_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/tb_bmdma_top.sv
module tb_bmdma_top;
  localparam int LW = 4;
  localparam int FULL = 1 << LW;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wd = '0, reg_rd_w;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wd, mem_rd;
  logic [1:0]  tx_valid, tx_ready, rx_valid, rx_ready, irq;
  logic [15:0] tx_data, rx_data;

  bmdma_top #(.NUM_CH(2), .LEN_W(LW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wd), .reg_rdata_o(reg_rd_w),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wd), .mem_rdata_i(mem_rd),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .irq_i(irq)
  );

  // memory model
  logic [7:0] mem [4096];
  logic       bw_en = 1'b0;
  logic [11:0] bw_a = '0;
  logic [7:0] bw_d = '0;
  always @(posedge clk) begin
    if (bw_en) mem[bw_a] <= bw_d;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wd;
      mem_rd <= mem[mem_addr[11:0]];
    end
  end

  // device stand-ins: mode 0 off, 1 sink (to device), 2 source (from device)
  int   dmode [2] = '{0, 0};
  int   dwant [2] = '{0, 0};
  bit   dirq_en [2] = '{0, 0};
  bit   dclr [2] = '{0, 0};
  int   dcnt [2];
  bit   irqd [2];
  logic [7:0] rec [2][64];

  function automatic logic [7:0] pat(input int c, input int i);
    return 8'(c * 64 + i * 7 + 1);
  endfunction
  function automatic logic [7:0] mpat(input int a);
    return 8'(a * 3 + 5);
  endfunction
  function automatic int eff(input int l);
    return (l == 0) ? FULL : l;
  endfunction

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (dclr[c]) begin
        dcnt[c] = 0; irqd[c] = 0;
        tx_ready[c] = 1'b0; rx_valid[c] = 1'b0; irq[c] = 1'b0; rx_data[c*8 +: 8] = '0;
      end else begin
        irq[c] = dmode[c] != 0 && dirq_en[c] && dcnt[c] >= dwant[c] && !irqd[c];
        if (irq[c]) irqd[c] = 1;
        tx_ready[c] = dmode[c] == 1 && dcnt[c] < dwant[c];
        rx_valid[c] = dmode[c] == 2 && dcnt[c] < dwant[c];
        rx_data[c*8 +: 8] = pat(c, dcnt[c]);
        if (tx_ready[c] && tx_valid[c]) begin
          rec[c][dcnt[c]] = tx_data[c*8 +: 8];
          dcnt[c]++;
        end else if (rx_valid[c] && rx_ready[c]) begin
          dcnt[c]++;
        end
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wd = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 v = reg_rd_w;
  endtask

  task automatic mem_put(input int a, input logic [7:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_a = 12'(a); bw_d = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic put_desc(input int t, input int a, input int cnt, input bit last);
    for (int k = 0; k < 4; k++) mem_put(t + k, 8'(a >> (8 * k)));
    mem_put(t + 4, 8'(cnt));
    mem_put(t + 5, 8'(cnt >> 8));
    mem_put(t + 6, 8'h5A);
    mem_put(t + 7, last ? 8'h80 : 8'h7F);
  endtask

  function automatic int tbl_of(input int ch);
    return ch ? 2048 : 0;
  endfunction

  task automatic dev_set(input int ch, input int mode, input int want, input bit ien);
    @(posedge clk);
    dmode[ch] = mode; dwant[ch] = want; dirq_en[ch] = ien; dclr[ch] = 1;
    @(posedge clk);
    dclr[ch] = 0;
  endtask

  // prepares buffers, table and registers; does not start
  task automatic prep(input int ch, input int dir, input int l0, input int l1, input int nd);
    int t, b0, b1;
    t = tbl_of(ch); b0 = t + 256; b1 = t + 512;
    if (dir == 0) begin
      for (int i = 0; i < eff(l0); i++) mem_put(b0 + i, mpat(b0 + i));
      if (nd == 2) for (int i = 0; i < eff(l1); i++) mem_put(b1 + i, mpat(b1 + i));
    end else begin
      for (int i = 0; i <= eff(l0); i++) mem_put(b0 + i, 8'hEE);
      if (nd == 2) for (int i = 0; i <= eff(l1); i++) mem_put(b1 + i, 8'hEE);
    end
    put_desc(t, b0, l0, nd == 1);
    if (nd == 2) put_desc(t + 8, b1, l1, 1'b1);
    reg_wr(ch * 8 + 0, 0);
    reg_wr(ch * 8 + 2, 32'h6);
    reg_wr(ch * 8 + 4, t | 3);
  endtask

  task automatic wait_idle(input int ch);
    logic [31:0] v;
    bit done;
    done = 0;
    for (int n = 0; n < 3000 && !done; n++) begin
      reg_rd(ch * 8 + 2, v);
      if (!v[0]) done = 1;
    end
    if (!done) chk("R6 run did not finish", 1, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_dev(input int ch, input int l0, input int l1, input int nd, input int n, input string tag);
    int b0, b1, e0;
    b0 = tbl_of(ch) + 256; b1 = tbl_of(ch) + 512; e0 = eff(l0);
    chk({tag, " byte count"}, dcnt[ch], n);
    for (int i = 0; i < n; i++)
      chk({tag, " to-device byte"}, rec[ch][i], (i < e0) ? mpat(b0 + i) : mpat(b1 + i - e0));
    if (nd == 1) chk({tag, " single desc"}, 0, 0);
  endtask

  task automatic check_mem(input int ch, input int l0, input int l1, input int nd, input string tag);
    int b0, b1, e0;
    b0 = tbl_of(ch) + 256; b1 = tbl_of(ch) + 512; e0 = eff(l0);
    for (int i = 0; i < e0; i++) chk({tag, " to-memory byte"}, mem[b0 + i], pat(ch, i));
    chk({tag, " guard after buffer 0"}, mem[b0 + e0], 8'hEE);
    if (nd == 2) begin
      for (int i = 0; i < eff(l1); i++) chk({tag, " to-memory byte"}, mem[b1 + i], pat(ch, e0 + i));
      chk({tag, " guard after buffer 1"}, mem[b1 + eff(l1)], 8'hEE);
    end
  endtask

  initial begin
    logic [31:0] v;
    int lens [4] = '{1, 2, 5, 0};
    rst_n = 1'b0;
    tx_ready = '0; rx_valid = '0; irq = '0; rx_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and register windows
    for (int a = 0; a < 16; a++) begin
      reg_rd(a, v);
      chk("R1 reset value", v, 0);
    end
    reg_wr(4, 32'h1234_5677);
    reg_wr(12, 32'hABCD_1237);
    reg_rd(4, v);  chk("R1 ch0 pointer low bits", v, 32'h1234_5674);
    reg_rd(12, v); chk("R1 ch1 pointer window", v, 32'hABCD_1234);
    reg_wr(8, 32'h8);
    reg_rd(8, v);  chk("R1 ch1 command readback", v, 32'h8);
    reg_rd(0, v);  chk("R1 ch0 command untouched", v, 0);
    reg_wr(8, 0);

    // R2 R3 R4 R5: sweep lengths, descriptor counts and directions
    for (int li = 0; li < 4; li++) begin
      for (int nd = 1; nd <= 2; nd++) begin
        for (int dir = 0; dir < 2; dir++) begin
          int ch, tot;
          ch  = (li + nd + dir) % 2;
          tot = eff(lens[li]) + ((nd == 2) ? 3 : 0);
          prep(ch, dir, lens[li], 3, nd);
          dev_set(ch, dir ? 2 : 1, tot, 1'b1);
          reg_wr(ch * 8, dir ? 32'h9 : 32'h1);
          wait_idle(ch);
          if (dir == 0) check_dev(ch, lens[li], 3, nd, tot, "R2 R3 R4 R5 sweep");
          else begin
            check_mem(ch, lens[li], 3, nd, "R3 R4 R5 sweep");
            chk("R5 source count", dcnt[ch], tot);
          end
          reg_rd(ch * 8 + 2, v);
          chk("R8 status after normal end", v, 32'h4);
        end
      end
    end

    // R7 write-1-to-clear on interrupt flag
    reg_wr(2, 32'h2); reg_rd(2, v); chk("R7 int kept on writing err bit", v, 32'h4);
    reg_wr(2, 32'h0); reg_rd(2, v); chk("R7 int kept on writing 0", v, 32'h4);
    reg_wr(2, 32'h4); reg_rd(2, v); chk("R7 int cleared", v, 32'h0);

    // R9 device keeps offering bytes after the table runs out
    prep(1, 1, 4, 0, 1);
    dev_set(1, 2, 6, 1'b0);
    reg_wr(8, 32'h9);
    wait_idle(1);
    reg_rd(10, v); chk("R9 exhaustion raises error", v, 32'h2);
    check_mem(1, 4, 0, 1, "R9 no overrun write");
    reg_wr(10, 32'h4); reg_rd(10, v); chk("R7 err kept on writing int bit", v, 32'h2);
    reg_wr(10, 32'h2); reg_rd(10, v); chk("R7 err cleared", v, 32'h0);

    // R8 early interrupt halts the run
    prep(0, 0, 8, 0, 1);
    dev_set(0, 1, 3, 1'b1);
    reg_wr(0, 32'h1);
    wait_idle(0);
    reg_rd(2, v); chk("R8 early interrupt status", v, 32'h4);
    chk("R8 bytes before halt", dcnt[0], 3);

    // R6 halt by clearing the start bit
    prep(0, 0, 5, 0, 1);
    dev_set(0, 1, 0, 1'b0);
    reg_wr(0, 32'h1);
    repeat (40) @(negedge clk);
    reg_rd(2, v); chk("R6 active while stalled", v, 32'h1);
    reg_wr(0, 32'h0);
    reg_rd(2, v); chk("R6 inactive after stop", v, 32'h0);
    chk("R6 nothing delivered", dcnt[0], 0);

    // R11 direction write during a run is ignored
    prep(0, 0, 6, 0, 1);
    dev_set(0, 1, 6, 1'b1);
    reg_wr(0, 32'h1);
    reg_wr(0, 32'h9);
    wait_idle(0);
    check_dev(0, 6, 0, 1, 6, "R11 run kept direction");
    for (int i = 0; i < 6; i++) chk("R11 buffer not written", mem[256 + i], mpat(256 + i));
    reg_rd(0, v); chk("R11 command readback", v, 32'h9);
    reg_rd(2, v); chk("R11 status", v, 32'h4);

    // R10 both channels at once on the shared memory port
    prep(0, 0, 0, 7, 2);
    prep(1, 1, 9, 0, 2);
    dev_set(0, 1, FULL + 7, 1'b1);
    dev_set(1, 2, 9 + FULL, 1'b1);
    reg_wr(0, 32'h1);
    reg_wr(8, 32'h9);
    wait_idle(0);
    wait_idle(1);
    check_dev(0, 0, 7, 2, FULL + 7, "R10 ch0 concurrent");
    check_mem(1, 9, 0, 2, "R10 ch1 concurrent");
    reg_rd(2, v);  chk("R10 ch0 status", v, 32'h4);
    reg_rd(10, v); chk("R10 ch1 status", v, 32'h4);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule